// File: doc/BRIEF.md
# Command-Code Register Access Port

This block sits behind a byte-level two-wire serial slave that serves one upstream master. It turns the byte stream into accesses to three eight-bit registers that a neighbouring ownership controller keeps: interrupt enable, control and interrupt status. The byte level tells it where a write segment begins and ends. It hands over each written byte and each read request. For every written byte the block returns an acknowledge decision, and for every read request it returns one data byte.

The first byte of each write segment is a command byte. Its two low bits pick the register, and bit 2 turns auto-increment on. When auto-increment is on, the pointer moves on after every data byte and every read. It does not wrap, so once it reaches the status register it stays there. Writes to the interrupt-enable and control registers leave the block as one-cycle write strobes with the data. The status register is read-only, so a write to it is refused.

All three byte paths use valid/ready. A written byte or read request is taken in on a clock edge where valid and ready are both high. Each response path has a single holding slot. While a response is waiting and its ready is low, the response holds steady and the matching input path drops its ready. A read request is never taken in a cycle where a written byte is offered.

Top module: `cmdreg_access_port`

## Requirements
- R1: After reset there is no pending response (ack_valid=0, rd_valid=0), wb_ready=1, no write strobe is active, the pointer selects interrupt enable (00b) and auto-increment is off.
- R2: The first byte accepted after bus_start or bus_stop is a command byte. It is always acknowledged and produces no write strobe. Its bits [1:0] load the pointer (00b enable, 01b control, 10b status, 11b invalid) and its bit 2 sets auto-increment.
- R3: A data byte whose pointer is 00b or 01b is acknowledged (ack_ok=1). In the cycle its acknowledge appears, exactly one strobe is high (ie_we for 00b, ctrl_we for 01b) and reg_wdata carries the byte.
- R4: A data byte whose pointer is 10b or 11b gets ack_ok=0 and no write strobe. No strobe is ever raised without an acknowledge.
- R5: A read returns ie_in, ctrl_in or stat_in as the pointer selects. With pointer 11b it returns 0x00.
- R6: With auto-increment on, the pointer steps after every data byte and read, 00b to 01b to 10b, and stays at 10b.
- R7: With auto-increment on, the third data byte after the command byte and every later one gets ack_ok=0 and no strobe.
- R8: With auto-increment off, the pointer is fixed for the segment, every data byte goes to the same register and there is no limit on the burst length.
- R9: bus_start or bus_stop resets the write-byte count. The pointer is kept, so later reads continue from it.
- R10: While a response is valid and its ready is low, its value stays stable and the input path that feeds it drops ready.
- R11: A response (ack_valid or rd_valid) appears in the cycle after its input is accepted. Read data is taken from the register inputs on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Pulse: START or repeated START seen |
| bus_stop | input | 1 | Pulse: STOP seen |
| wb_valid | input | 1 | Written byte offered |
| wb_ready | output | 1 | Written byte can be taken |
| wb_data | input | 8 | Written byte |
| ack_valid | output | 1 | Acknowledge decision pending |
| ack_ready | input | 1 | Acknowledge consumed |
| ack_ok | output | 1 | 1 = ACK, 0 = NACK |
| rd_req_valid | input | 1 | Read byte requested |
| rd_req_ready | output | 1 | Read request can be taken |
| rd_valid | output | 1 | Read data pending |
| rd_ready | input | 1 | Read data consumed |
| rd_data | output | 8 | Read data |
| ie_in | input | 8 | Interrupt-enable register value |
| ctrl_in | input | 8 | Control register value |
| stat_in | input | 8 | Interrupt-status register value |
| ie_we | output | 1 | Write strobe, interrupt enable |
| ctrl_we | output | 1 | Write strobe, control |
| reg_wdata | output | 8 | Data carried with a write strobe |

## Verification
An acknowledge and any write strobe for a byte both appear in the cycle after the byte is accepted. Read data also appears one cycle after the request is accepted. The bench drives on falling edges and samples one nanosecond later, so every sample falls between edges. A driver task pushes each expected acknowledge, strobe and read byte into its own queue before offering the input. Monitors pop an entry only on a cycle where the response is valid and ready, so a held response is compared once. A separate back-pressure sequence keeps ack_ready low for several cycles and checks the response and wb_ready at each one.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    SEL_IE   = 2'b00,
    SEL_CTRL = 2'b01,
    SEL_STAT = 2'b10,
    SEL_BAD  = 2'b11
  } sel_e;

  // Saturating pointer step: never wraps past the status register.
  function automatic sel_e sel_step(input sel_e cur);
    case (cur)
      SEL_IE:   sel_step = SEL_CTRL;
      SEL_CTRL: sel_step = SEL_STAT;
      default:  sel_step = cur;
    endcase
  endfunction

  function automatic logic sel_writable(input sel_e cur);
    sel_writable = (cur == SEL_IE) || (cur == SEL_CTRL);
  endfunction
endpackage

// File: rtl/cap_resp_slot.sv
// One-entry response holding slot with valid/ready on its output.
module cap_resp_slot #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_load,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_load) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (out_ready) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cap_rd_sel.sv
// Read-data selection from the live register values.
module cap_rd_sel #(
  parameter int unsigned DW = 8
) (
  input  cap_pkg::sel_e    sel,
  input  logic [DW-1:0]    ie_in,
  input  logic [DW-1:0]    ctrl_in,
  input  logic [DW-1:0]    stat_in,
  output logic [DW-1:0]    data
);
  import cap_pkg::*;
  always_comb begin
    case (sel)
      SEL_IE:   data = ie_in;
      SEL_CTRL: data = ctrl_in;
      SEL_STAT: data = stat_in;
      default:  data = '0;
    endcase
  end
endmodule

// File: rtl/cap_ptr_ctrl.sv
// Pointer, auto-increment flag, write-byte count and acknowledge decision.
module cap_ptr_ctrl #(
  parameter int unsigned DW        = 8,
  parameter int unsigned AI_BIT    = 2,
  parameter int unsigned BURST_MAX = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           seg_start,
  input  logic           seg_stop,
  input  logic           wr_fire,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_fire,
  output cap_pkg::sel_e  ptr,
  output logic           ack_dec,
  output logic           ie_we,
  output logic           ctrl_we,
  output logic [DW-1:0]  wdata
);
  import cap_pkg::*;

  localparam int unsigned CW      = $clog2(BURST_MAX + 2);
  localparam logic [CW-1:0] CNT_TOP = CW'(BURST_MAX + 1);
  localparam logic [CW-1:0] CNT_LIM = CW'(BURST_MAX);

  sel_e          ptr_q;
  logic          ai_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_eff;
  logic          is_cmd;
  logic          over;
  logic          ie_we_q, ctrl_we_q;
  logic [DW-1:0] wdata_q;

  // A segment boundary in the same cycle takes effect first.
  assign cnt_eff = (seg_start || seg_stop) ? '0 : cnt_q;
  assign is_cmd  = (cnt_eff == '0);
  assign over    = ai_q && (cnt_eff > CNT_LIM);
  assign ack_dec = is_cmd || (!over && sel_writable(ptr_q));

  assign ptr     = ptr_q;
  assign ie_we   = ie_we_q;
  assign ctrl_we = ctrl_we_q;
  assign wdata   = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= SEL_IE;
      ai_q  <= 1'b0;
      cnt_q <= '0;
    end else if (wr_fire) begin
      if (is_cmd) begin
        ptr_q <= sel_e'(wr_data[1:0]);
        ai_q  <= wr_data[AI_BIT];
        cnt_q <= CW'(1);
      end else begin
        cnt_q <= (cnt_eff < CNT_TOP) ? cnt_eff + CW'(1) : cnt_eff;
        if (ai_q) ptr_q <= sel_step(ptr_q);
      end
    end else begin
      cnt_q <= cnt_eff;
      if (rd_fire && ai_q) ptr_q <= sel_step(ptr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_we_q   <= 1'b0;
      ctrl_we_q <= 1'b0;
      wdata_q   <= '0;
    end else begin
      ie_we_q   <= wr_fire && !is_cmd && !over && (ptr_q == SEL_IE);
      ctrl_we_q <= wr_fire && !is_cmd && !over && (ptr_q == SEL_CTRL);
      if (wr_fire) wdata_q <= wr_data;
    end
  end
endmodule

// File: rtl/cmdreg_access_port.sv
module cmdreg_access_port #(
  parameter int unsigned DW        = 8,
  parameter int unsigned AI_BIT    = 2,
  parameter int unsigned BURST_MAX = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic          wb_valid,
  output logic          wb_ready,
  input  logic [DW-1:0] wb_data,
  output logic          ack_valid,
  input  logic          ack_ready,
  output logic          ack_ok,
  input  logic          rd_req_valid,
  output logic          rd_req_ready,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] ie_in,
  input  logic [DW-1:0] ctrl_in,
  input  logic [DW-1:0] stat_in,
  output logic          ie_we,
  output logic          ctrl_we,
  output logic [DW-1:0] reg_wdata
);
  import cap_pkg::*;

  logic          wr_fire, rd_fire;
  logic          ack_slot_rdy, rd_slot_rdy;
  logic          ack_dec;
  logic [DW-1:0] sel_data;
  sel_e          cur_ptr;

  assign wb_ready     = ack_slot_rdy;
  assign rd_req_ready = rd_slot_rdy && !wb_valid;
  assign wr_fire      = wb_valid && wb_ready;
  assign rd_fire      = rd_req_valid && rd_req_ready;

  cap_ptr_ctrl #(.DW(DW), .AI_BIT(AI_BIT), .BURST_MAX(BURST_MAX)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .seg_start(bus_start), .seg_stop(bus_stop),
    .wr_fire(wr_fire), .wr_data(wb_data), .rd_fire(rd_fire),
    .ptr(cur_ptr), .ack_dec(ack_dec),
    .ie_we(ie_we), .ctrl_we(ctrl_we), .wdata(reg_wdata)
  );

  cap_rd_sel #(.DW(DW)) u_sel (
    .sel(cur_ptr), .ie_in(ie_in), .ctrl_in(ctrl_in), .stat_in(stat_in),
    .data(sel_data)
  );

  cap_resp_slot #(.W(1)) u_ack_slot (
    .clk(clk), .rst_n(rst_n),
    .in_load(wr_fire), .in_ready(ack_slot_rdy), .in_data(ack_dec),
    .out_valid(ack_valid), .out_ready(ack_ready), .out_data(ack_ok)
  );

  cap_resp_slot #(.W(DW)) u_rd_slot (
    .clk(clk), .rst_n(rst_n),
    .in_load(rd_fire), .in_ready(rd_slot_rdy), .in_data(sel_data),
    .out_valid(rd_valid), .out_ready(rd_ready), .out_data(rd_data)
  );
endmodule

// File: rtl/cap_access_chk.sv
module cap_access_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wb_valid,
  input logic          wb_ready,
  input logic          ack_valid,
  input logic          ack_ready,
  input logic          ack_ok,
  input logic          rd_req_valid,
  input logic          rd_req_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data,
  input logic          ie_we,
  input logic          ctrl_we,
  input logic [1:0]    cur_ptr
);
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ready) |=> (ack_valid && $stable(ack_ok)));          // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));           // R10
  AST_WB_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ready) |-> !wb_ready);                              // R10
  AST_ACK_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready) |=> ack_valid);                                 // R11
  AST_RD_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready) |=> rd_valid);                          // R11
  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ie_we, ctrl_we}));                                           // R3
  AST_STROBE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_we || ctrl_we) |-> (ack_valid && ack_ok));                         // R4
  AST_PTR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready && cur_ptr == 2'b10) |=> (cur_ptr == 2'b10)); // R6
  AST_BAD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready && cur_ptr == 2'b11) |=> (rd_data == '0));     // R5
endmodule

bind cmdreg_access_port cap_access_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .wb_valid(wb_valid), .wb_ready(wb_ready),
  .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_ok(ack_ok),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .ie_we(ie_we), .ctrl_we(ctrl_we), .cur_ptr(cur_ptr)
);

// File: tb/cmdreg_access_port_tb_top.sv
`timescale 1ns/1ps
module cmdreg_access_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_start = 1'b0, bus_stop = 1'b0;
  logic       wb_valid = 1'b0;
  logic       wb_ready;
  logic [7:0] wb_data = '0;
  logic       ack_valid, ack_ok;
  logic       ack_ready = 1'b1;
  logic       rd_req_valid = 1'b0;
  logic       rd_req_ready, rd_valid;
  logic       rd_ready = 1'b1;
  logic [7:0] rd_data;
  logic [7:0] ie_in = 8'h03, ctrl_in = 8'h45, stat_in = 8'h07;
  logic       ie_we, ctrl_we;
  logic [7:0] reg_wdata;

  int n_chk = 0;
  int n_fail = 0;

  bit         ack_q[$];
  string      ack_t[$];
  logic [9:0] we_q[$];   // {kind(1=ie,2=ctrl), data}
  string      we_t[$];
  logic [7:0] rd_q[$];
  string      rd_t[$];

  always #10 clk = ~clk;  // 50 MHz

  cmdreg_access_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_data(wb_data),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_ok(ack_ok),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .ie_in(ie_in), .ctrl_in(ctrl_in), .stat_in(stat_in),
    .ie_we(ie_we), .ctrl_we(ctrl_we), .reg_wdata(reg_wdata)
  );

  function automatic void chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Monitor: sample 1 ns after each falling edge.
  logic [9:0] we_e;
  logic [9:0] we_a;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (ack_valid && ack_ready) begin
        if (ack_q.size() == 0) chk(1'b0, "R11", "unexpected ack", ack_ok, 0);
        else chk(ack_ok == ack_q[0], ack_t[0], "ack_ok", ack_ok, ack_q[0]);
        if (ack_q.size() != 0) begin void'(ack_q.pop_front()); void'(ack_t.pop_front()); end
      end
      if (rd_valid && rd_ready) begin
        if (rd_q.size() == 0) chk(1'b0, "R11", "unexpected read", rd_data, 0);
        else chk(rd_data == rd_q[0], rd_t[0], "rd_data", rd_data, rd_q[0]);
        if (rd_q.size() != 0) begin void'(rd_q.pop_front()); void'(rd_t.pop_front()); end
      end
      if (ie_we || ctrl_we) begin
        we_a = {ctrl_we, ie_we, reg_wdata};
        if (we_q.size() == 0) chk(1'b0, "R4", "unexpected strobe", we_a, 0);
        else begin
          we_e = we_q.pop_front();
          chk(we_a == we_e, we_t.pop_front(), "strobe", we_a, we_e);
        end
      end
    end
  end

  task automatic seg(input bit is_stop);
    @(negedge clk);
    if (is_stop) bus_stop = 1'b1; else bus_start = 1'b1;
    @(negedge clk);
    bus_stop = 1'b0; bus_start = 1'b0;
  endtask

  // kind: 0 none, 1 ie, 2 ctrl
  task automatic put_byte(input logic [7:0] d, input bit ok, input int kind, input string tag);
    ack_q.push_back(ok); ack_t.push_back(tag);
    if (kind != 0) begin we_q.push_back({kind[1:0], d}); we_t.push_back(tag); end
    @(negedge clk);
    wb_valid = 1'b1; wb_data = d;
    #1;
    while (!wb_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    wb_valid = 1'b0;
    #1;
    chk(ack_valid == 1'b1, "R11", "ack one cycle after accept", ack_valid, 1);
  endtask

  task automatic get_byte(input logic [7:0] exp, input string tag);
    rd_q.push_back(exp); rd_t.push_back(tag);
    @(negedge clk);
    rd_req_valid = 1'b1;
    #1;
    while (!rd_req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    rd_req_valid = 1'b0;
    #1;
    chk(rd_valid == 1'b1, "R11", "read one cycle after accept", rd_valid, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(ack_valid == 1'b0, "R1", "ack_valid after reset", ack_valid, 0);
    chk(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
    chk(wb_ready == 1'b1, "R1", "wb_ready after reset", wb_ready, 1);
    chk({ie_we, ctrl_we} == 2'b00, "R1", "strobes after reset", {ie_we, ctrl_we}, 0);
    get_byte(8'h03, "R1");           // pointer 00b, no auto-increment
    get_byte(8'h03, "R1");

    // R8: control, no auto-increment, long burst
    seg(0);
    put_byte(8'h01, 1, 0, "R2");
    put_byte(8'h11, 1, 2, "R3");
    put_byte(8'h22, 1, 2, "R8");
    put_byte(8'h33, 1, 2, "R8");
    seg(1);
    get_byte(8'h45, "R9");
    get_byte(8'h45, "R8");

    // R7/R6: auto-increment write from enable
    seg(0);
    put_byte(8'h04, 1, 0, "R2");
    put_byte(8'hA1, 1, 1, "R6");
    put_byte(8'hB2, 1, 2, "R6");
    put_byte(8'hC3, 0, 0, "R7");
    put_byte(8'hD4, 0, 0, "R7");
    seg(1);
    get_byte(8'h07, "R6");
    get_byte(8'h07, "R6");

    // R4: status and invalid pointers refuse writes; R5 invalid read
    seg(0);
    put_byte(8'h02, 1, 0, "R2");
    put_byte(8'h55, 0, 0, "R4");
    seg(0);
    put_byte(8'h03, 1, 0, "R2");
    put_byte(8'h66, 0, 0, "R4");
    seg(1);
    get_byte(8'h00, "R5");

    // R6: auto-increment reads saturate; register values are live
    seg(0);
    put_byte(8'h04, 1, 0, "R2");
    seg(1);
    ie_in = 8'h5A; ctrl_in = 8'hC1; stat_in = 8'h02;
    get_byte(8'h5A, "R5");
    get_byte(8'hC1, "R6");
    get_byte(8'h02, "R6");
    get_byte(8'h02, "R6");

    // Auto-increment from control: second data byte lands on status
    seg(0);
    put_byte(8'h05, 1, 0, "R2");
    put_byte(8'h77, 1, 2, "R6");
    put_byte(8'h78, 0, 0, "R4");
    seg(1);

    // R9: STOP resets the count, next byte is a command again
    seg(0);
    put_byte(8'h01, 1, 0, "R2");
    seg(1);
    seg(0);
    put_byte(8'h00, 1, 0, "R9");   // command, pointer 00b
    get_byte(8'h5A, "R9");

    // R10: back-pressure on the acknowledge path
    seg(0);
    ack_q.push_back(1'b1); ack_t.push_back("R10");
    @(negedge clk);
    ack_ready = 1'b0;
    wb_valid = 1'b1; wb_data = 8'h01;
    @(negedge clk);
    wb_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(ack_valid && ack_ok, "R10", "held acknowledge", {ack_valid, ack_ok}, 3);
      chk(wb_ready == 1'b0, "R10", "wb_ready low while stalled", wb_ready, 0);
      @(negedge clk);
    end
    ack_ready = 1'b1;
    put_byte(8'h9A, 1, 2, "R3");
    seg(1);

    // R10: back-pressure on the read path
    rd_q.push_back(8'hC1); rd_t.push_back("R10");
    @(negedge clk);
    rd_ready = 1'b0;
    rd_req_valid = 1'b1;
    @(negedge clk);
    rd_req_valid = 1'b0;
    ctrl_in = 8'h3C;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(rd_valid && rd_data == 8'hC1, "R10", "held read data", rd_data, 8'hC1);
      chk(rd_req_ready == 1'b0, "R10", "rd_req_ready low while stalled", rd_req_ready, 0);
      @(negedge clk);
    end
    rd_ready = 1'b1;

    repeat (4) @(negedge clk);
    #2;
    chk(ack_q.size() == 0, "R11", "acks outstanding", ack_q.size(), 0);
    chk(rd_q.size() == 0, "R11", "reads outstanding", rd_q.size(), 0);
    chk(we_q.size() == 0, "R3", "strobes outstanding", we_q.size(), 0);
    summary();
    $finish;
  end
endmodule